// File: doc/BRIEF.md
# Per-Core Local Tick Timer Bank

This block provides a bank of identical countdown timers, one per processor core. Each core has its own 256-byte register window on a shared 32-bit register bus and its own interrupt line. A timer counts in two stages. A prescale stage divides the input clock by (prescale value + 1). An interval stage counts those prescaled ticks down from a 31-bit reload value. When the interval stage runs out, the timer latches a pending interrupt.

Software stages the interval reload value through a buffer register. The value is taken only when the commit flag in the written word is set, so a partial or stray write cannot disturb a running period. A per-core control register starts and stops the counters, arms the interrupt output and picks between a repeating mode and a single-shot mode. Every write to the prescale, interval or control register sets a matching acknowledge bit. Software clears that bit by writing 1 to it.

Top module: `ltmr_bank`

## Requirements
- R1: After reset every register of every core reads 0 and every interrupt output is low.
- R2: Core n's window starts at byte address 0x300 + 0x100·n. Its registers sit at these offsets: prescale value at 0x00 (32 bits, read back in full), interval reload at 0x08 (bits 30:0, bit 31 reads 0), control at 0x20, pending status at 0x30 (bit 0), interrupt enable at 0x34 (bit 0) and write acknowledge at 0x40. Unmapped offsets read 0.
- R3: A write to the interval reload register changes the stored value only when bit 31 of the written word is 1. In that case bits 30:0 are stored.
- R4: Control bit 0 (run) is written from 0 to 1 on clock edge E. With prescale value P and interval reload N, the pending status bit 0 becomes 1 after edge E + N·(P+1). A reload of 0 behaves as 1.
- R5: With control bit 2 (repeat) set, the timer reloads itself on expiry and expires again every N·(P+1) cycles.
- R6: With control bit 2 clear, an expiry clears control bit 0 and the timer does not expire again until software restarts it.
- R7: Clearing control bit 0 freezes both counter stages, so no expiry occurs while the timer is stopped. Setting bit 0 again reloads both stages from their buffers.
- R8: Writing 1 to bit 0 of the pending status register clears it. Writing 0 leaves it unchanged.
- R9: A core's interrupt output is high exactly when its pending bit, its enable bit 0 and its control bit 1 (interrupt arm) are all 1.
- R10: A write to the prescale register sets acknowledge bit 0. A write to the interval reload register sets bit 1. A write to control sets bit 3. Writing 1 to an acknowledge bit clears it, and writing 0 leaves it unchanged.
- R11: Cores are independent. Activity in one core's window never changes another core's registers or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | NUM_CORES | One interrupt per core |

## Verification
The bench checks the expiry cycle exactly. It checks that the output is low one cycle before the computed edge and high one cycle after it. A prescaler or interval counter that is off by one therefore shows up as an early or late edge. A restart after a stop must wait a full period. A design that resumes the frozen count instead fires too early. A one-shot timer that keeps its run bit would raise the pending bit again after software has cleared it. Writes to the interval reload register without the commit flag, and writes of 0 to the W1C registers, are read back to show they had no effect. The bench also runs the second core alone, so a decoder that aliases the windows would raise the wrong interrupt.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
   localparam int unsigned BUS_W = 32;
   // first window index (0x300 >> 8) and window spacing of 0x100
   localparam int unsigned WIN_FIRST = 3;
   localparam int unsigned WIN_BITS  = 8;

   localparam logic [7:0] OFS_PRESC = 8'h00;
   localparam logic [7:0] OFS_RELOAD = 8'h08;
   localparam logic [7:0] OFS_CTRL  = 8'h20;
   localparam logic [7:0] OFS_PEND  = 8'h30;
   localparam logic [7:0] OFS_IEN   = 8'h34;
   localparam logic [7:0] OFS_WACK  = 8'h40;

   localparam int unsigned COMMIT_BIT = 31;
   localparam int unsigned ACK_PRESC  = 0;
   localparam int unsigned ACK_RELOAD = 1;
   localparam int unsigned ACK_CTRL   = 3;
   localparam logic [3:0]  ACK_MASK   = 4'b1011;

   typedef struct packed {
      logic periodic;   // bit 2
      logic irq_arm;    // bit 1
      logic run;        // bit 0
   } ctrl_t;
endpackage

// File: rtl/ltmr_prescaler.sv
module ltmr_prescaler #(
   parameter int unsigned PRE_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             run_i,
   input  logic [PRE_W-1:0] reload_i,
   output logic             tick_o
);
   logic [PRE_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (load_i)              cnt_q <= reload_i;
      else if (run_i) begin
         if (cnt_q == '0)           cnt_q <= reload_i;
         else                       cnt_q <= cnt_q - 1'b1;
      end
   end

   assign tick_o = run_i && !load_i && (cnt_q == '0);

   // R7: a stopped prescaler holds its count
   a_r7_prescale_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ltmr_interval.sv
module ltmr_interval #(
   parameter int unsigned CNT_W = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   logic [CNT_W-1:0] cnt_q;
   logic             last;

   assign last     = (cnt_q <= ONE);
   assign expire_o = tick_i && !load_i && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (load_i)              cnt_q <= reload_i;
      else if (tick_i) begin
         if (last)                  cnt_q <= reload_i;
         else                       cnt_q <= cnt_q - 1'b1;
      end
   end

   // R4: the interval count only moves on a prescaled tick or a load
   a_r4_interval_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !load_i) |=> $stable(cnt_q));
   // R4: a tick above the last step lowers the count by exactly one
   a_r4_interval_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !load_i && !last) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/ltmr_core.sv
module ltmr_core
   import ltmr_pkg::*;
#(
   parameter int unsigned PRE_W = 32,
   parameter int unsigned CNT_W = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_ofs,
   input  logic [BUS_W-1:0] wr_data,
   input  logic [7:0]       rd_ofs,
   output logic [BUS_W-1:0] rd_data,
   output logic             irq
);
   ctrl_t            ctrl_q;
   logic [PRE_W-1:0] presc_q;
   logic [CNT_W-1:0] reload_q;
   logic             pend_q;
   logic             ien_q;
   logic [3:0]       wack_q;
   logic [3:0]       wack_n;

   logic wr_presc, wr_reload, wr_ctrl, wr_pend, wr_ien, wr_wack;
   logic start_load, tick, expire;

   assign wr_presc  = wr_en && (wr_ofs == OFS_PRESC);
   assign wr_reload = wr_en && (wr_ofs == OFS_RELOAD);
   assign wr_ctrl   = wr_en && (wr_ofs == OFS_CTRL);
   assign wr_pend   = wr_en && (wr_ofs == OFS_PEND);
   assign wr_ien    = wr_en && (wr_ofs == OFS_IEN);
   assign wr_wack   = wr_en && (wr_ofs == OFS_WACK);

   assign start_load = wr_ctrl && wr_data[0] && !ctrl_q.run;

   ltmr_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (start_load),
      .run_i    (ctrl_q.run),
      .reload_i (presc_q),
      .tick_o   (tick)
   );

   ltmr_interval #(.CNT_W(CNT_W)) u_ivl (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (start_load),
      .tick_i   (tick),
      .reload_i (reload_q),
      .expire_o (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc_q  <= '0;
         reload_q <= '0;
         ien_q    <= 1'b0;
      end else begin
         if (wr_presc)                        presc_q  <= wr_data[PRE_W-1:0];
         if (wr_reload && wr_data[COMMIT_BIT]) reload_q <= wr_data[CNT_W-1:0];
         if (wr_ien)                          ien_q    <= wr_data[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              ctrl_q     <= '0;
      else if (wr_ctrl)                        ctrl_q     <= ctrl_t'(wr_data[2:0]);
      else if (expire && !ctrl_q.periodic)     ctrl_q.run <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    pend_q <= 1'b0;
      else if (expire)               pend_q <= 1'b1;
      else if (wr_pend && wr_data[0]) pend_q <= 1'b0;
   end

   always_comb begin
      wack_n = wack_q;
      if (wr_wack)   wack_n = wack_n & ~wr_data[3:0];
      if (wr_presc)  wack_n[ACK_PRESC]  = 1'b1;
      if (wr_reload) wack_n[ACK_RELOAD] = 1'b1;
      if (wr_ctrl)   wack_n[ACK_CTRL]   = 1'b1;
      wack_n = wack_n & ACK_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wack_q <= '0;
      else        wack_q <= wack_n;
   end

   assign irq = pend_q && ien_q && ctrl_q.irq_arm;

   always_comb begin
      case (rd_ofs)
         OFS_PRESC:  rd_data = BUS_W'(presc_q);
         OFS_RELOAD: rd_data = BUS_W'(reload_q);
         OFS_CTRL:   rd_data = BUS_W'(ctrl_q);
         OFS_PEND:   rd_data = BUS_W'(pend_q);
         OFS_IEN:    rd_data = BUS_W'(ien_q);
         OFS_WACK:   rd_data = BUS_W'(wack_q);
         default:    rd_data = '0;
      endcase
   end

   // R3: a write without the commit flag keeps the stored reload
   a_r3_reload_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_reload && !wr_data[COMMIT_BIT]) |=> $stable(reload_q));
   // R4: an expiry always leaves the pending bit set
   a_r4_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> pend_q);
   // R6: single-shot expiry drops the run bit
   a_r6_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !ctrl_q.periodic && !wr_ctrl) |=> !ctrl_q.run);
   // R7: no expiry while stopped
   a_r7_no_expire_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.run |-> !expire);
   // R9: interrupt only with enable set
   a_r9_irq_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien_q && pend_q));
   // R10: control write is acknowledged
   a_r10_ctrl_ack: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> wack_q[ACK_CTRL]);
endmodule

// File: rtl/ltmr_bank.sv
module ltmr_bank
   import ltmr_pkg::*;
#(
   parameter int unsigned NUM_CORES = 2,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned PRE_W     = 32,
   parameter int unsigned CNT_W     = 31
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   output logic [NUM_CORES-1:0] irq
);
   localparam int unsigned WIN_W = ADDR_W - WIN_BITS;

   initial begin
      assert (NUM_CORES >= 1 && WIN_FIRST + NUM_CORES <= (1 << WIN_W))
         else $error("ltmr_bank: windows do not fit the address width");
      assert (PRE_W >= 1 && PRE_W <= BUS_W)
         else $error("ltmr_bank: PRE_W out of range");
      assert (CNT_W >= 2 && CNT_W <= COMMIT_BIT)
         else $error("ltmr_bank: CNT_W out of range");
   end

   logic [WIN_W-1:0]    win;
   logic [7:0]          ofs;
   logic [BUS_W-1:0]    rd_core [NUM_CORES];
   logic [NUM_CORES-1:0] hit;

   assign win = bus_addr[ADDR_W-1:WIN_BITS];
   assign ofs = bus_addr[WIN_BITS-1:0];

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
      assign hit[i] = (win == WIN_W'(WIN_FIRST + i));

      ltmr_core #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_core (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (bus_wr && hit[i]),
         .wr_ofs  (ofs),
         .wr_data (bus_wdata),
         .rd_ofs  (ofs),
         .rd_data (rd_core[i]),
         .irq     (irq[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CORES; i++)
         if (hit[i]) bus_rdata = bus_rdata | rd_core[i];
   end

   // R11: the windows never overlap
   a_r11_one_window: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
endmodule

// File: tb/test_ltmr_bank.sv
module test_ltmr_bank;
   localparam time CLK_PERIOD = 10ns;
   localparam int  ADDR_W = 12;
   localparam logic [11:0] C0 = 12'h300, C1 = 12'h400;
   localparam logic [7:0] PRESC = 8'h00, RELOAD = 8'h08, CTRL = 8'h20,
                          PEND = 8'h30, IEN = 8'h34, WACK = 8'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  irq;
   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ltmr_bank #(.NUM_CORES(2), .ADDR_W(ADDR_W)) i_ltmr_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] base, logic [7:0] ofs, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = base | 12'(ofs); bus_wdata = d;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic rd(logic [11:0] base, logic [7:0] ofs, output logic [31:0] d);
      @(negedge clk);
      bus_addr = base | 12'(ofs);
      #1 d = bus_rdata;
   endtask

   // called just after the start edge E; expects irq[idx] low before E+k, high after
   task automatic expect_fire(int idx, int k, string tag);
      repeat (k-1) @(posedge clk);
      @(negedge clk);
      check({tag, " low before expiry"}, 32'(irq[idx]), 32'd0);
      @(posedge clk);
      @(negedge clk);
      check({tag, " high at expiry"}, 32'(irq[idx]), 32'd1);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 irq after reset", 32'(irq), 32'd0);
      foreach (d[i]) ; // no-op keeps d declared
      rd(C0, PRESC, d);  check("R1 prescale", d, 0);
      rd(C0, CTRL, d);   check("R1 control", d, 0);
      rd(C1, WACK, d);   check("R1 ack", d, 0);
   endtask

   task automatic t_regmap();
      logic [31:0] d;
      wr(C0, PRESC, 32'hA5A5_0001);
      wr(C0, RELOAD, 32'h8000_0005);
      wr(C0, CTRL, 32'h0000_0006);
      rd(C0, PRESC, d);  check("R2 prescale readback", d, 32'hA5A5_0001);
      rd(C0, RELOAD, d); check("R2 reload readback", d, 32'h5);
      rd(C0, CTRL, d);   check("R2 control readback", d, 32'h6);
      rd(C0, 8'h10, d);  check("R2 unmapped", d, 0);
      rd(C1, PRESC, d);  check("R11 other core untouched", d, 0);
      wr(C0, RELOAD, 32'h0000_0009);
      rd(C0, RELOAD, d); check("R3 uncommitted write ignored", d, 32'h5);
      rd(C0, WACK, d);   check("R10 ack bits set", d, 32'hB);
      wr(C0, WACK, 32'h0);
      rd(C0, WACK, d);   check("R10 write 0 keeps ack", d, 32'hB);
      wr(C0, WACK, 32'h2);
      rd(C0, WACK, d);   check("R10 clear reload ack", d, 32'h9);
      wr(C0, WACK, 32'hB);
      rd(C0, WACK, d);   check("R10 clear all ack", d, 32'h0);
      wr(C0, CTRL, 32'h0);
   endtask

   task automatic t_oneshot();
      logic [31:0] d;
      wr(C0, PRESC, 32'd1);
      wr(C0, RELOAD, 32'h8000_0003);
      wr(C0, IEN, 32'd1);
      wr(C0, CTRL, 32'h3);
      expect_fire(0, 6, "R4 single-shot P=1 N=3");
      rd(C0, CTRL, d);   check("R6 run bit cleared", d, 32'h2);
      wr(C0, PEND, 32'h1);
      repeat (20) @(posedge clk);
      @(negedge clk);
      check("R6 no second expiry irq", 32'(irq[0]), 0);
      rd(C0, PEND, d);   check("R6 no second expiry pend", d, 0);
   endtask

   task automatic t_gating();
      logic [31:0] d;
      wr(C0, IEN, 32'd0);
      wr(C0, CTRL, 32'h3);
      repeat (12) @(posedge clk);
      rd(C0, PEND, d);   check("R9 pending set", d, 1);
      check("R9 enable low blocks irq", 32'(irq[0]), 0);
      wr(C0, IEN, 32'd1);
      @(negedge clk);
      check("R9 enable raises irq", 32'(irq[0]), 1);
      wr(C0, CTRL, 32'h0);
      @(negedge clk);
      check("R9 arm low blocks irq", 32'(irq[0]), 0);
      wr(C0, PEND, 32'h0);
      rd(C0, PEND, d);   check("R8 write 0 keeps pending", d, 1);
      wr(C0, PEND, 32'h1);
      rd(C0, PEND, d);   check("R8 write 1 clears pending", d, 0);
   endtask

   task automatic t_periodic();
      wr(C0, PRESC, 32'd2);
      wr(C0, RELOAD, 32'h8000_0002);
      wr(C0, CTRL, 32'h7);
      expect_fire(0, 6, "R5 first period");
      wr(C0, PEND, 32'h1);       // commits at E+8
      expect_fire(0, 4, "R5 second period");
      wr(C0, CTRL, 32'h0);
      wr(C0, PEND, 32'h1);
   endtask

   task automatic t_freeze();
      logic [31:0] d;
      wr(C0, PRESC, 32'd0);
      wr(C0, RELOAD, 32'h8000_000A);
      wr(C0, CTRL, 32'h7);
      repeat (3) @(posedge clk);
      wr(C0, CTRL, 32'h6);
      repeat (30) @(posedge clk);
      rd(C0, PEND, d);   check("R7 stopped timer no expiry", d, 0);
      wr(C0, CTRL, 32'h7);
      expect_fire(0, 10, "R7 restart full reload");
      wr(C0, CTRL, 32'h0);
      wr(C0, PEND, 32'h1);
   endtask

   task automatic t_core1();
      wr(C1, PRESC, 32'd0);
      wr(C1, RELOAD, 32'h8000_0004);
      wr(C1, IEN, 32'd1);
      wr(C1, CTRL, 32'h3);
      expect_fire(1, 4, "R11 core1 expiry");
      check("R11 core0 irq quiet", 32'(irq[0]), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_oneshot();
      t_gating();
      t_periodic();
      t_freeze();
      t_core1();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule